// File: doc/BRIEF.md
# Ethernet Pseudowire Header Classifier

This block reads the header of each received Ethernet frame as a byte stream and decides where the frame goes. It steps through the destination address, the frame format (plain type field or an 802.2 LLC/SNAP wrapper) and up to two VLAN tags. It then reads the EtherType and, for IP frames, the protocol number. From these it picks one of six pseudowire encapsulations: MEF-8, MFA-8, UDP over IPv4, UDP over IPv6, L2TPv3 over IPv4 or L2TPv3 over IPv6. For a recognised frame it reports the byte offset where the pseudowire header starts.

A frame that fails a check is sent either to the CPU or to discard. Each kind of failure has its own steering input, so software can choose which unrecognised traffic it wants to see. The verdict is a single-cycle pulse, given once per frame. Bytes that arrive after the verdict are ignored, so the block can sit directly on the receive path with no buffering.

Top module: `pw_hdr_classifier`

## Requirements
- R1: The destination address (first six bytes, first byte compared with bits 47:40 of the configured value) is accepted when it equals `cfg_addr0`, `cfg_addr1` or FF-FF-FF-FF-FF-FF.
- R2: A destination address that matches none of the three gives verdict CPU (`out_kind`=1) when `cfg_da_to_cpu` is 1 and DISCARD (`out_kind`=2) when it is 0.
- R3: A type/length value of 1500 or less selects LLC/SNAP framing. The next six bytes must be AA AA 03 00 00 00, and the EtherType follows them. Any other value in those six bytes is a format failure, which is steered by `cfg_type_to_cpu`.
- R4: One VLAN tag is accepted when its TPID equals `cfg_tpid_inner`. Two tags are accepted when the first equals `cfg_tpid_outer` and the second equals `cfg_tpid_inner`. An outer tag that is not followed by an inner tag is a format failure, steered by `cfg_type_to_cpu`. Tags are not allowed after SNAP.
- R5: EtherType 0x88D8 gives MEF-8 (`out_pw_type`=0) and EtherType `cfg_mfa_etype` gives MFA-8 (`out_pw_type`=1). In both cases `out_hdr_ofs` is the index of the byte that follows the EtherType.
- R6: For EtherType 0x0800, IP protocol 17 (UDP) gives type 2 and protocol 115 (L2TPv3) gives type 4. The offset is the IPv4 start plus four times the header-length nibble (low nibble of the first IP byte). The protocol is taken from IP byte 9.
- R7: For EtherType 0x86DD, next header 17 gives type 3 and next header 115 gives type 5. The offset is the IPv6 start plus 40. The next header is taken from IP byte 6.
- R8: Bit 0 of `cfg_ip_mode` allows IPv4 and bit 1 allows IPv6. A disallowed IP EtherType is treated as unrecognised.
- R9: Any other EtherType, or a type/length value after SNAP that is 1500 or less, gives CPU or DISCARD according to `cfg_type_to_cpu`.
- R10: An IP protocol other than 17 or 115 gives CPU or DISCARD according to `cfg_proto_to_cpu`.
- R11: A frame that ends (`in_eof`) before a verdict is reached gives DISCARD. A start-of-frame that arrives while a frame is still undecided also gives DISCARD for the old frame.
- R12: Exactly one verdict is given per frame, registered one cycle after the deciding byte. Bytes after the verdict, including the end-of-frame byte, are ignored until the next start-of-frame. For verdicts other than PW, `out_pw_type` and `out_hdr_ofs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_addr0 | input | 48 | First station address |
| cfg_addr1 | input | 48 | Second station address |
| cfg_tpid_inner | input | 16 | TPID for a single tag or for the inner of two tags |
| cfg_tpid_outer | input | 16 | TPID for the outer of two tags |
| cfg_mfa_etype | input | 16 | EtherType that marks MFA-8 |
| cfg_ip_mode | input | 2 | bit0 allows IPv4, bit1 allows IPv6 |
| cfg_da_to_cpu | input | 1 | Address miss: 1 CPU, 0 discard |
| cfg_type_to_cpu | input | 1 | Format or EtherType failure: 1 CPU, 0 discard |
| cfg_proto_to_cpu | input | 1 | IP protocol failure: 1 CPU, 0 discard |
| out_valid | output | 1 | One-cycle verdict pulse |
| out_kind | output | 2 | 0 pseudowire, 1 CPU, 2 discard |
| out_pw_type | output | 3 | Encapsulation code, see R5 to R7 |
| out_hdr_ofs | output | 8 | Byte offset of the pseudowire header |

## Verification
The hardest cases to reach are the deepest classification paths, where tags, SNAP and an IP header stack up. In those frames the offset depends on every earlier field. There are also the abort cases: a frame cut short inside the IP header, and a new start-of-frame while the old frame is still undecided. The bench assembles frames field by field, so tags, SNAP, IP header length and truncation point can be combined freely. It computes each expected offset from where it placed the fields, and it inserts idle gaps between bytes so that the per-field counters must hold across stalls. Trailing payload that imitates a second header checks that nothing after the verdict is looked at.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int MAC_BYTES     = 6;
    localparam int POS_W         = $clog2(MAC_BYTES);
    localparam int CNT_W         = 6;
    localparam int OFS_W         = 8;
    localparam int N_KEYS        = 3;
    localparam int KEY_W         = MAC_BYTES * 8;
    localparam int SNAP_BYTES    = 6;
    localparam int IP4_PROTO_IDX = 9;
    localparam int IP6_NH_IDX    = 6;
    localparam int IP6_HDR_LEN   = 40;

    localparam logic [15:0] ET_IP4   = 16'h0800;
    localparam logic [15:0] ET_IP6   = 16'h86DD;
    localparam logic [15:0] ET_MEF   = 16'h88D8;
    localparam logic [15:0] MAX_LEN  = 16'd1500;
    localparam logic [7:0]  PR_UDP   = 8'd17;
    localparam logic [7:0]  PR_L2TP  = 8'd115;

    typedef enum logic [1:0] {
        VK_PW   = 2'd0,
        VK_CPU  = 2'd1,
        VK_DROP = 2'd2
    } verdict_e;

    typedef enum logic [2:0] {
        PW_MEF8  = 3'd0,
        PW_MFA8  = 3'd1,
        PW_UDP4  = 3'd2,
        PW_UDP6  = 3'd3,
        PW_L2TP4 = 3'd4,
        PW_L2TP6 = 3'd5
    } pw_e;

    typedef enum logic [2:0] {
        TC_MEF, TC_MFA, TC_IP4, TC_IP6, TC_LEN, TC_OTHER
    } tclass_e;

    typedef enum logic [2:0] {
        S_IDLE, S_DA, S_SA, S_TYPE, S_TCI, S_SNAP, S_IP4, S_IP6
    } walk_e;
endpackage

// File: rtl/pwc_byte_match.sv
module pwc_byte_match
    import pwc_pkg::*;
#(
    parameter int NK = N_KEYS,
    parameter int KB = MAC_BYTES,
    parameter int PW = POS_W
) (
    input  logic [7:0]         byte_in,
    input  logic [PW-1:0]      pos,
    input  logic [NK*KB*8-1:0] keys,
    output logic [NK-1:0]      hit
);
    localparam int KW = KB * 8;

    for (genvar k = 0; k < NK; k++) begin : g_key
        logic [KW-1:0] key_v;
        logic [7:0]    sel_v;
        assign key_v = keys[k*KW +: KW];
        always_comb begin
            sel_v = '0;
            for (int b = 0; b < KB; b++) begin
                if (pos == PW'(b)) sel_v = key_v[(KB-1-b)*8 +: 8];
            end
        end
        assign hit[k] = (sel_v == byte_in);
    end
endmodule

// File: rtl/pwc_type_decode.sv
module pwc_type_decode
    import pwc_pkg::*;
(
    input  logic [15:0] tval,
    input  logic [15:0] mfa_etype,
    output tclass_e     cls
);
    always_comb begin
        if (tval == ET_MEF)          cls = TC_MEF;
        else if (tval == mfa_etype)  cls = TC_MFA;
        else if (tval == ET_IP4)     cls = TC_IP4;
        else if (tval == ET_IP6)     cls = TC_IP6;
        else if (tval <= MAX_LEN)    cls = TC_LEN;
        else                         cls = TC_OTHER;
    end
endmodule

// File: rtl/pw_hdr_classifier.sv
module pw_hdr_classifier
    import pwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [47:0]       cfg_addr0,
    input  logic [47:0]       cfg_addr1,
    input  logic [15:0]       cfg_tpid_inner,
    input  logic [15:0]       cfg_tpid_outer,
    input  logic [15:0]       cfg_mfa_etype,
    input  logic [1:0]        cfg_ip_mode,
    input  logic              cfg_da_to_cpu,
    input  logic              cfg_type_to_cpu,
    input  logic              cfg_proto_to_cpu,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [2:0]        out_pw_type,
    output logic [OFS_W-1:0]  out_hdr_ofs
);
    typedef struct packed {
        walk_e             st;
        logic [CNT_W-1:0]  cnt;
        logic [OFS_W-1:0]  idx;
        logic [N_KEYS-1:0] hit;
        logic [7:0]        hi;
        logic              seen_out;
        logic              seen_in;
        logic              snap;
        logic [3:0]        ihl;
        logic [OFS_W-1:0]  ipst;
        logic              ov;
        verdict_e          ok;
        pw_e               opw;
        logic [OFS_W-1:0]  oofs;
    } cls_t;

    cls_t q, n;

    logic [N_KEYS-1:0]       hit_now;
    logic [POS_W-1:0]        mpos;
    logic [N_KEYS*KEY_W-1:0] keyset;
    logic [15:0]             tval;
    tclass_e                 tcls;

    assign mpos   = in_sof ? '0 : q.cnt[POS_W-1:0];
    assign keyset = {{KEY_W{1'b1}}, cfg_addr1, cfg_addr0};
    assign tval   = {q.hi, in_data};

    pwc_byte_match #(.NK(N_KEYS), .KB(MAC_BYTES), .PW(POS_W)) u_match (
        .byte_in (in_data),
        .pos     (mpos),
        .keys    (keyset),
        .hit     (hit_now)
    );

    pwc_type_decode u_tdec (
        .tval      (tval),
        .mfa_etype (cfg_mfa_etype),
        .cls       (tcls)
    );

    function automatic logic [7:0] snap_expect(input logic [CNT_W-1:0] c);
        if (c < CNT_W'(2))       return 8'hAA;
        else if (c == CNT_W'(2)) return 8'h03;
        else                     return 8'h00;
    endfunction

    logic             emit;
    verdict_e         ek;
    pw_e              ep;
    logic [OFS_W-1:0] eo;
    verdict_e         type_fail;
    verdict_e         proto_fail;

    assign type_fail  = cfg_type_to_cpu  ? VK_CPU : VK_DROP;
    assign proto_fail = cfg_proto_to_cpu ? VK_CPU : VK_DROP;

    always_comb begin
        n    = q;
        n.ov = 1'b0;
        emit = 1'b0;
        ek   = VK_DROP;
        ep   = PW_MEF8;
        eo   = '0;
        if (in_valid && in_sof) begin
            n.ov       = (q.st != S_IDLE) || in_eof;
            n.ok       = VK_DROP;
            n.opw      = PW_MEF8;
            n.oofs     = '0;
            n.st       = in_eof ? S_IDLE : S_DA;
            n.cnt      = CNT_W'(1);
            n.idx      = OFS_W'(1);
            n.hit      = hit_now;
            n.seen_out = 1'b0;
            n.seen_in  = 1'b0;
            n.snap     = 1'b0;
        end else if (in_valid && q.st != S_IDLE) begin
            n.idx = q.idx + OFS_W'(1);
            case (q.st)
                S_DA: begin
                    n.hit = q.hit & hit_now;
                    if (q.cnt == CNT_W'(MAC_BYTES - 1)) begin
                        if (|(q.hit & hit_now)) begin
                            n.st  = S_SA;
                            n.cnt = '0;
                        end else begin
                            emit = 1'b1;
                            ek   = cfg_da_to_cpu ? VK_CPU : VK_DROP;
                        end
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_SA: begin
                    if (q.cnt == CNT_W'(MAC_BYTES - 1)) begin
                        n.st  = S_TYPE;
                        n.cnt = '0;
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_TYPE: begin
                    if (q.cnt == '0) begin
                        n.hi  = in_data;
                        n.cnt = CNT_W'(1);
                    end else begin
                        n.cnt = '0;
                        if (!q.snap && !q.seen_in && !q.seen_out &&
                            tval == cfg_tpid_outer && cfg_tpid_outer != cfg_tpid_inner) begin
                            n.seen_out = 1'b1;
                            n.st       = S_TCI;
                        end else if (!q.snap && !q.seen_in && tval == cfg_tpid_inner) begin
                            n.seen_in = 1'b1;
                            n.st      = S_TCI;
                        end else if (q.seen_out && !q.seen_in) begin
                            emit = 1'b1;
                            ek   = type_fail;
                        end else begin
                            case (tcls)
                                TC_LEN: begin
                                    if (!q.snap) begin
                                        n.st = S_SNAP;
                                    end else begin
                                        emit = 1'b1;
                                        ek   = type_fail;
                                    end
                                end
                                TC_MEF: begin
                                    emit = 1'b1;
                                    ek   = VK_PW;
                                    ep   = PW_MEF8;
                                    eo   = q.idx + OFS_W'(1);
                                end
                                TC_MFA: begin
                                    emit = 1'b1;
                                    ek   = VK_PW;
                                    ep   = PW_MFA8;
                                    eo   = q.idx + OFS_W'(1);
                                end
                                TC_IP4: begin
                                    if (cfg_ip_mode[0]) begin
                                        n.st   = S_IP4;
                                        n.ipst = q.idx + OFS_W'(1);
                                    end else begin
                                        emit = 1'b1;
                                        ek   = type_fail;
                                    end
                                end
                                TC_IP6: begin
                                    if (cfg_ip_mode[1]) begin
                                        n.st   = S_IP6;
                                        n.ipst = q.idx + OFS_W'(1);
                                    end else begin
                                        emit = 1'b1;
                                        ek   = type_fail;
                                    end
                                end
                                default: begin
                                    emit = 1'b1;
                                    ek   = type_fail;
                                end
                            endcase
                        end
                    end
                end
                S_TCI: begin
                    if (q.cnt == '0) begin
                        n.cnt = CNT_W'(1);
                    end else begin
                        n.cnt = '0;
                        n.st  = S_TYPE;
                    end
                end
                S_SNAP: begin
                    if (in_data != snap_expect(q.cnt)) begin
                        emit = 1'b1;
                        ek   = type_fail;
                    end else if (q.cnt == CNT_W'(SNAP_BYTES - 1)) begin
                        n.cnt  = '0;
                        n.st   = S_TYPE;
                        n.snap = 1'b1;
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_IP4: begin
                    if (q.cnt == '0) n.ihl = in_data[3:0];
                    if (q.cnt == CNT_W'(IP4_PROTO_IDX)) begin
                        emit = 1'b1;
                        if (in_data == PR_UDP || in_data == PR_L2TP) begin
                            ek = VK_PW;
                            ep = (in_data == PR_UDP) ? PW_UDP4 : PW_L2TP4;
                            eo = q.ipst + (OFS_W'(q.ihl) << 2);
                        end else begin
                            ek = proto_fail;
                        end
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_IP6: begin
                    if (q.cnt == CNT_W'(IP6_NH_IDX)) begin
                        emit = 1'b1;
                        if (in_data == PR_UDP || in_data == PR_L2TP) begin
                            ek = VK_PW;
                            ep = (in_data == PR_UDP) ? PW_UDP6 : PW_L2TP6;
                            eo = q.ipst + OFS_W'(IP6_HDR_LEN);
                        end else begin
                            ek = proto_fail;
                        end
                    end else begin
                        n.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
            if (emit) begin
                n.ov   = 1'b1;
                n.ok   = ek;
                n.opw  = ep;
                n.oofs = eo;
                n.st   = S_IDLE;
            end else if (in_eof) begin
                n.ov   = 1'b1;
                n.ok   = VK_DROP;
                n.opw  = PW_MEF8;
                n.oofs = '0;
                n.st   = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.ok   <= VK_DROP;
            q.opw  <= PW_MEF8;
        end else begin
            q <= n;
        end
    end

    assign out_valid   = q.ov;
    assign out_kind    = q.ok;
    assign out_pw_type = q.opw;
    assign out_hdr_ofs = q.oofs;

    // R1
    da_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DA && in_valid && !in_sof) |=> !(out_valid && out_kind == VK_PW));

    // R5
    ofs_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == VK_PW) |-> (out_hdr_ofs >= OFS_W'(2 * MAC_BYTES + 2)));

    // R12
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && !(in_valid && in_sof)) |=> !out_valid);

    // R11
    early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SA && in_valid && in_eof && !in_sof) |=> (out_valid && out_kind == VK_DROP));
endmodule

// File: tb/pw_hdr_classifier_tb.sv
module pw_hdr_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [47:0] cfg_addr0 = 48'h02_11_22_33_44_55;
    logic [47:0] cfg_addr1 = 48'h02_AA_BB_CC_DD_EE;
    logic [15:0] cfg_tpid_inner = 16'h8100;
    logic [15:0] cfg_tpid_outer = 16'h88A8;
    logic [15:0] cfg_mfa_etype = 16'h88E5;
    logic [1:0]  cfg_ip_mode = 2'b11;
    logic        cfg_da_to_cpu = 1'b1, cfg_type_to_cpu = 1'b1, cfg_proto_to_cpu = 1'b1;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [2:0]  out_pw_type;
    logic [7:0]  out_hdr_ofs;

    localparam logic [47:0] SRC = 48'h0A_0B_0C_0D_0E_0F;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam int K_PW = 0, K_CPU = 1, K_DROP = 2;

    always #5 clk = ~clk;

    pw_hdr_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .cfg_addr0(cfg_addr0), .cfg_addr1(cfg_addr1),
        .cfg_tpid_inner(cfg_tpid_inner), .cfg_tpid_outer(cfg_tpid_outer),
        .cfg_mfa_etype(cfg_mfa_etype), .cfg_ip_mode(cfg_ip_mode),
        .cfg_da_to_cpu(cfg_da_to_cpu), .cfg_type_to_cpu(cfg_type_to_cpu),
        .cfg_proto_to_cpu(cfg_proto_to_cpu), .out_valid(out_valid), .out_kind(out_kind),
        .out_pw_type(out_pw_type), .out_hdr_ofs(out_hdr_ofs)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int qk[$], qp[$], qo[$];
    string qt[$];

    logic [7:0] fb [0:255];
    int flen;

    task automatic fail_line(string req, string what, int act, int exp);
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    task automatic fb_clear(); flen = 0; endtask
    task automatic fb_byte(input logic [7:0] b); fb[flen] = b; flen++; endtask
    task automatic fb_16(input logic [15:0] v); fb_byte(v[15:8]); fb_byte(v[7:0]); endtask
    task automatic fb_mac(input logic [47:0] a);
        for (int i = 5; i >= 0; i--) fb_byte(a[i*8 +: 8]);
    endtask
    task automatic fb_eth(input logic [47:0] da); fb_clear(); fb_mac(da); fb_mac(SRC); endtask
    task automatic fb_snap(input logic [15:0] len);
        fb_16(len); fb_byte(8'hAA); fb_byte(8'hAA); fb_byte(8'h03);
        fb_byte(8'h00); fb_byte(8'h00); fb_byte(8'h00);
    endtask
    task automatic fb_ip4(input logic [7:0] proto, input int ihl);
        for (int i = 0; i < ihl * 4; i++)
            fb_byte(i == 0 ? {4'h4, 4'(ihl)} : (i == 9 ? proto : 8'(8'h50 + i)));
    endtask
    task automatic fb_ip6(input logic [7:0] nh);
        for (int i = 0; i < 40; i++) fb_byte(i == 0 ? 8'h60 : (i == 6 ? nh : 8'(8'h30 + i)));
    endtask
    task automatic fb_pad(input int n);
        for (int i = 0; i < n; i++) fb_byte(8'(8'hC0 + i));
    endtask

    task automatic expect_v(input int k, input int p, input int o, input string tag);
        qk.push_back(k); qp.push_back(p); qo.push_back(o); qt.push_back(tag);
    endtask

    task automatic play(input bit with_eof, input bit gaps);
        for (int i = 0; i < flen; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = with_eof && (i == flen - 1);
            in_data = fb[i];
        end
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (qk.size() == 0) begin
                fail_line("R12", "unexpected verdict kind", int'(out_kind), -1);
            end else begin
                int k, p, o;
                string t;
                k = qk.pop_front(); p = qp.pop_front(); o = qo.pop_front(); t = qt.pop_front();
                if (int'(out_kind) != k)         fail_line(t, "kind", int'(out_kind), k);
                else if (int'(out_pw_type) != p) fail_line(t, "pw type", int'(out_pw_type), p);
                else if (int'(out_hdr_ofs) != o) fail_line(t, "offset", int'(out_hdr_ofs), o);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            while (qk.size() > 0) begin
                n_tests++;
                fail_line(qt.pop_front(), "missing verdict", 0, 1);
                void'(qk.pop_front()); void'(qp.pop_front()); void'(qo.pop_front());
            end
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        fail_line("WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int o;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) fail_line("R12", "reset out_valid", int'(out_valid), 0);

        // R1 three accepted addresses, R5 MEF/MFA offsets
        fb_eth(cfg_addr0); fb_16(16'h88D8); o = flen; fb_pad(8);
        expect_v(K_PW, 0, o, "R1"); play(1, 0);
        fb_eth(cfg_addr1); fb_16(cfg_mfa_etype); o = flen; fb_pad(8);
        expect_v(K_PW, 1, o, "R5"); play(1, 1);
        fb_eth(BCAST); fb_16(16'h0800); o = flen + 20; fb_ip4(8'd17, 5); fb_pad(4);
        expect_v(K_PW, 2, o, "R6"); play(1, 0);

        // R2 address miss steering
        fb_eth(48'h02_11_22_33_44_56); fb_16(16'h88D8); fb_pad(4);
        expect_v(K_CPU, 0, 0, "R2"); play(1, 0);
        cfg_da_to_cpu = 1'b0;
        expect_v(K_DROP, 0, 0, "R2"); play(1, 1);
        cfg_da_to_cpu = 1'b1;

        // R3 SNAP with IPv4 L2TPv3 IHL 6, boundary length 1500
        fb_eth(cfg_addr0); fb_snap(16'd1500); fb_16(16'h0800); o = flen + 24; fb_ip4(8'd115, 6);
        expect_v(K_PW, 4, o, "R3"); play(1, 0);
        fb_eth(cfg_addr0); fb_snap(16'd64); fb[16] = 8'h13; fb_16(16'h88D8); fb_pad(2);
        expect_v(K_CPU, 0, 0, "R3"); play(1, 0);

        // R4 tags
        fb_eth(cfg_addr0); fb_16(16'h8100); fb_16(16'h0005); fb_16(16'h86DD);
        o = flen + 40; fb_ip6(8'd17);
        expect_v(K_PW, 3, o, "R4"); play(1, 1);
        fb_eth(cfg_addr1); fb_16(16'h88A8); fb_16(16'h0010); fb_16(16'h8100); fb_16(16'h0020);
        fb_16(16'h88D8); o = flen; fb_pad(3);
        expect_v(K_PW, 0, o, "R4"); play(1, 0);
        cfg_type_to_cpu = 1'b0;
        fb_eth(cfg_addr0); fb_16(16'h88A8); fb_16(16'h0010); fb_16(16'h88D8); fb_pad(3);
        expect_v(K_DROP, 0, 0, "R4"); play(1, 0);
        cfg_type_to_cpu = 1'b1;
        fb_eth(cfg_addr0); fb_16(16'h9100); fb_16(16'h0010); fb_16(16'h88D8); fb_pad(3);
        expect_v(K_CPU, 0, 0, "R4"); play(1, 0);

        // R5 MFA with tag and SNAP
        fb_eth(cfg_addr0); fb_16(16'h8100); fb_16(16'h0001); fb_snap(16'd46);
        fb_16(cfg_mfa_etype); o = flen; fb_pad(2);
        expect_v(K_PW, 1, o, "R5"); play(1, 0);

        // R7 IPv6 L2TPv3
        fb_eth(cfg_addr1); fb_16(16'h86DD); o = flen + 40; fb_ip6(8'd115);
        expect_v(K_PW, 5, o, "R7"); play(1, 0);

        // R8 IP version mode
        cfg_ip_mode = 2'b01;
        fb_eth(cfg_addr0); fb_16(16'h86DD); fb_ip6(8'd17);
        expect_v(K_CPU, 0, 0, "R8"); play(1, 0);
        fb_eth(cfg_addr0); fb_16(16'h0800); o = flen + 20; fb_ip4(8'd17, 5);
        expect_v(K_PW, 2, o, "R8"); play(1, 0);
        cfg_ip_mode = 2'b10;
        fb_eth(cfg_addr0); fb_16(16'h0800); fb_ip4(8'd17, 5);
        expect_v(K_CPU, 0, 0, "R8"); play(1, 0);
        cfg_ip_mode = 2'b00;
        fb_eth(cfg_addr0); fb_16(16'h86DD); fb_ip6(8'd17);
        expect_v(K_CPU, 0, 0, "R8"); play(1, 0);
        cfg_ip_mode = 2'b11;

        // R9 unknown EtherType, 1501, length after SNAP
        fb_eth(cfg_addr0); fb_16(16'h1234); fb_pad(4);
        expect_v(K_CPU, 0, 0, "R9"); play(1, 0);
        cfg_type_to_cpu = 1'b0;
        fb_eth(cfg_addr0); fb_16(16'd1501); fb_pad(8);
        expect_v(K_DROP, 0, 0, "R9"); play(1, 0);
        fb_eth(cfg_addr0); fb_snap(16'd80); fb_16(16'd80); fb_pad(4);
        expect_v(K_DROP, 0, 0, "R9"); play(1, 0);
        cfg_type_to_cpu = 1'b1;

        // R10 unknown protocol
        fb_eth(cfg_addr0); fb_16(16'h0800); fb_ip4(8'd6, 5);
        expect_v(K_CPU, 0, 0, "R10"); play(1, 0);
        cfg_proto_to_cpu = 1'b0;
        fb_eth(cfg_addr0); fb_16(16'h86DD); fb_ip6(8'd58);
        expect_v(K_DROP, 0, 0, "R10"); play(1, 1);
        cfg_proto_to_cpu = 1'b1;

        // R11 truncation and abort
        fb_eth(cfg_addr0); fb_16(16'h0800); fb_ip4(8'd17, 5); flen = 20;
        expect_v(K_DROP, 0, 0, "R11"); play(1, 0);
        fb_eth(cfg_addr0); flen = 8;
        expect_v(K_DROP, 0, 0, "R11"); play(1, 0);
        fb_eth(cfg_addr0); fb_16(16'h8100); flen = 15;
        expect_v(K_DROP, 0, 0, "R11"); play(0, 0);
        fb_eth(cfg_addr1); fb_16(16'h88D8); o = flen; fb_pad(2);
        expect_v(K_PW, 0, o, "R11"); play(1, 0);

        // R12 trailing bytes that look like another header are ignored
        fb_eth(cfg_addr0); fb_16(16'h88D8); o = flen;
        fb_mac(cfg_addr0); fb_mac(SRC); fb_16(16'h0800); fb_ip4(8'd6, 5);
        expect_v(K_PW, 0, o, "R12"); play(1, 1);
        fb_eth(48'h0); fb_16(16'h88D8); fb_pad(30);
        expect_v(K_CPU, 0, 0, "R12"); play(1, 0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule